// File: doc/BRIEF.md
# Descriptor-Chained Multi-Channel DMA Sequencer

This block is a five-channel DMA address engine. Each channel follows a list of two-word descriptors held in main memory. From the current descriptor it takes a buffer address, a word count, a direction and a final-entry marker. It then issues one 32-bit memory access for each word the attached device asks to move. When a buffer runs dry, the engine does three things on its own: it writes a completion word back into the descriptor, steps the channel's list pointer by eight bytes, and fetches the next descriptor. The processor is not involved in any of these steps.

All channels share one address incrementer and one count decrementer. The per-channel list pointers and buffer contexts sit in two banked register files. Device requests are served in round-robin order, with one word per grant, over a single memory-master port. That port has a valid/ready request side and a separate response strobe. A small slave register port sets a channel's list pointer, starts and stops the channel, clears its completion flag, and reads its live state back.

Top module: `dchain_dma`

## Requirements
- R1: After reset every channel is stopped, `irq_done` is zero, no memory request is raised and every register reads zero.
- R2: Register address = {channel, field}. Field 0 holds the list pointer (read/write). Writing field 1 with bit 0 set starts the channel, which first reads the descriptor word at the pointer and then the word at pointer+4. In the first word, bits 15:0 are the word count, bit 31 is the final marker and bit 30 is the direction (1 = memory to device). The second word is the buffer address.
- R3: In memory-to-device mode, the channel makes one read per word at the buffer address, address+4, and so on. Each returned word appears on `dev_rd_data` together with a `dev_ack` pulse for that channel. The count never goes below zero.
- R4: In device-to-memory mode, the channel writes its `dev_wr_data` slice to successive word addresses. `dev_ack` pulses when each write is accepted.
- R5: When the count reaches zero, the engine writes a status word to the descriptor's first word: bit 31 is the final marker, bit 30 the direction, bit 29 is set, and all other bits are 0. The list pointer then reads back increased by 8.
- R6: If the completed descriptor is not final, the next descriptor is fetched from the advanced pointer without any register write.
- R7: After a final descriptor, the channel stops and its `irq_done` bit is set. Writing field 1 with bit 1 set clears that bit, and so does a restart.
- R8: Requesting running channels are served round-robin. Each grant moves at most one data word, and at most one `dev_ack` bit is high at a time.
- R9: A request holds its address and write flag until accepted. No request is raised while a read response is still owed.
- R10: A channel that is stopped (field 1 written with bit 0 clear), or whose `dev_req` is low, causes no memory access.
- R11: A descriptor with count 0 moves no data. Its status word is written right after the fetch.
- R12: Field 1 reads as {last at bit 3, direction at bit 2, done at bit 1, run at bit 0}. Field 2 reads the current buffer address and field 3 the remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | 5 | Per-channel device transfer request |
| dev_wr_data | input | 160 | Per-channel word for device-to-memory moves, channel c in bits 32c+31:32c |
| dev_ack | output | 5 | One-hot pulse when a word completes for a channel |
| dev_rd_data | output | 32 | Word read from memory, valid with `dev_ack` |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Read data |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | {channel[4:2], field[1:0]} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_done | output | 5 | Per-channel list-complete flag |

## Verification
The embedded properties check, on every cycle, the memory handshake rules: requests stay stable while stalled, and no request is issued while a read is still pending. They also check that at most one channel is granted or acknowledged at a time, that the count never underflows, and that a channel is stopped whenever its done flag rises. Several behaviours can only be shown by the scenarios, which compare every memory transaction and every device acknowledge against a predicted stream. These are the exact address order through descriptor chaining, the status word contents, the rotation order across three competing channels, the silence of stopped or idle channels, and the readback values.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
    localparam int DW        = 32;
    localparam int CW        = 16;
    localparam int STEP      = 4;
    localparam int LAST_BIT  = 31;
    localparam int DIR_BIT   = 30;
    localparam int DONE_BIT  = 29;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_D0_REQ,
        ST_D0_RSP,
        ST_D1_REQ,
        ST_D1_RSP,
        ST_XF_REQ,
        ST_XF_RSP,
        ST_STAT,
        ST_ADV1,
        ST_ADV2
    } st_e;

    typedef struct packed {
        logic [DW-1:0] addr;
        logic [CW-1:0] cnt;
        logic          last;
        logic          dir;
    } ctx_t;
endpackage

// File: rtl/dchain_rr_arb.sv
module dchain_rr_arb #(
    parameter int N = 5,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          advance,
    output logic          grant_valid,
    output logic [IW-1:0] grant_idx
);
    typedef struct packed {
        logic [IW-1:0] ptr;
    } arb_t;

    arb_t         arb_d, arb_q;
    logic [N-1:0] grant;

    always_comb begin
        grant       = '0;
        grant_idx   = '0;
        grant_valid = 1'b0;
        for (int off = 1; off <= N; off++) begin
            int idx;
            idx = (int'(arb_q.ptr) + off) % N;
            if (!grant_valid && req[idx]) begin
                grant_valid = 1'b1;
                grant[idx]  = 1'b1;
                grant_idx   = IW'(idx);
            end
        end
        arb_d = arb_q;
        if (advance && grant_valid) begin
            arb_d.ptr = grant_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arb_q.ptr <= IW'(N - 1);
        end else begin
            arb_q <= arb_d;
        end
    end

    assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_grant_requested_R10: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> ((grant & ~req) == '0) && (|req));
endmodule

// File: rtl/dchain_ctx_bank.sv
module dchain_ctx_bank
    import dchain_pkg::*;
#(
    parameter int N = 5,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  eng_pp_we,
    input  logic [IW-1:0]         eng_idx,
    input  logic [DW-1:0]         eng_pp_wdata,
    input  logic                  ctx_we,
    input  ctx_t                  ctx_wdata,
    input  logic                  sw_pp_we,
    input  logic [IW-1:0]         sw_idx,
    input  logic [DW-1:0]         sw_pp_wdata,
    output logic [N-1:0][DW-1:0]  pp_o,
    output ctx_t [N-1:0]          ctx_o
);
    typedef struct packed {
        logic [N-1:0][DW-1:0] pp;
        ctx_t [N-1:0]         ctx;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < N; i++) begin
            if (sw_pp_we && sw_idx == IW'(i)) begin
                bank_d.pp[i] = sw_pp_wdata;
            end
            if (eng_pp_we && eng_idx == IW'(i)) begin
                bank_d.pp[i] = eng_pp_wdata;
            end
            if (ctx_we && eng_idx == IW'(i)) begin
                bank_d.ctx[i] = ctx_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign pp_o  = bank_q.pp;
    assign ctx_o = bank_q.ctx;

    assert_engine_pp_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_pp_we |=> pp_o[$past(eng_idx)] == $past(eng_pp_wdata));
endmodule

// File: rtl/dchain_step_unit.sv
module dchain_step_unit
    import dchain_pkg::*;
(
    input  logic [DW-1:0] inc_in,
    output logic [DW-1:0] inc_out,
    input  logic [CW-1:0] dec_in,
    output logic [CW-1:0] dec_out,
    output logic          dec_zero
);
    always_comb begin
        inc_out  = inc_in + DW'(STEP);
        dec_out  = dec_in - CW'(1);
        dec_zero = (dec_out == '0);
    end
endmodule

// File: rtl/dchain_dma.sv
module dchain_dma
    import dchain_pkg::*;
#(
    parameter int NCH = 5,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int RAW = CHW + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCH-1:0]     dev_req,
    input  logic [NCH*DW-1:0]  dev_wr_data,
    output logic [NCH-1:0]     dev_ack,
    output logic [DW-1:0]      dev_rd_data,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic               mem_req_write,
    output logic [DW-1:0]      mem_req_addr,
    output logic [DW-1:0]      mem_req_wdata,
    input  logic               mem_rsp_valid,
    input  logic [DW-1:0]      mem_rsp_data,
    input  logic               reg_wr,
    input  logic [RAW-1:0]     reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rdata,
    output logic [NCH-1:0]     irq_done
);
    typedef struct packed {
        st_e            st;
        logic [CHW-1:0] cur;
        logic [NCH-1:0] run;
        logic [NCH-1:0] need;
        logic [NCH-1:0] done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NCH-1:0][DW-1:0] pp_all;
    ctx_t [NCH-1:0]         ctx_all;
    ctx_t                   cur_ctx, ctx_w;
    logic [DW-1:0]          cur_pp, pp_w;
    logic                   ctx_we, pp_we;
    logic                   arb_adv, arb_valid;
    logic [CHW-1:0]         arb_idx;
    logic [DW-1:0]          inc_in, inc_out;
    logic [CW-1:0]          dec_out;
    logic                   dec_zero;
    logic [NCH-1:0]         eligible;
    logic [CHW-1:0]         sw_ch;
    logic [1:0]             sw_fld;
    logic                   sw_hit, sw_pp_we;
    logic [DW-1:0]          status_word;

    assign sw_ch    = reg_addr[RAW-1:2];
    assign sw_fld   = reg_addr[1:0];
    assign sw_hit   = int'(sw_ch) < NCH;
    assign sw_pp_we = reg_wr && sw_hit && (sw_fld == 2'd0);
    assign cur_ctx  = ctx_all[ctl_q.cur];
    assign cur_pp   = pp_all[ctl_q.cur];
    assign eligible = ctl_q.run & dev_req;
    assign dev_rd_data = mem_rsp_data;
    assign irq_done = ctl_q.done;

    dchain_rr_arb #(.N(NCH)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (eligible),
        .advance     (arb_adv),
        .grant_valid (arb_valid),
        .grant_idx   (arb_idx)
    );

    dchain_ctx_bank #(.N(NCH)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .eng_pp_we    (pp_we),
        .eng_idx      (ctl_q.cur),
        .eng_pp_wdata (pp_w),
        .ctx_we       (ctx_we),
        .ctx_wdata    (ctx_w),
        .sw_pp_we     (sw_pp_we),
        .sw_idx       (sw_ch),
        .sw_pp_wdata  (reg_wdata),
        .pp_o         (pp_all),
        .ctx_o        (ctx_all)
    );

    dchain_step_unit u_step (
        .inc_in   (inc_in),
        .inc_out  (inc_out),
        .dec_in   (cur_ctx.cnt),
        .dec_out  (dec_out),
        .dec_zero (dec_zero)
    );

    always_comb begin
        status_word           = '0;
        status_word[LAST_BIT] = cur_ctx.last;
        status_word[DIR_BIT]  = cur_ctx.dir;
        status_word[DONE_BIT] = 1'b1;
    end

    always_comb begin
        ctl_d         = ctl_q;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        dev_ack       = '0;
        ctx_we        = 1'b0;
        ctx_w         = cur_ctx;
        pp_we         = 1'b0;
        pp_w          = inc_out;
        arb_adv       = 1'b0;
        inc_in        = cur_pp;

        case (ctl_q.st)
            ST_IDLE: begin
                if (arb_valid) begin
                    arb_adv   = 1'b1;
                    ctl_d.cur = arb_idx;
                    ctl_d.st  = ctl_q.need[arb_idx] ? ST_D0_REQ : ST_XF_REQ;
                end
            end
            ST_D0_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = cur_pp;
                if (mem_req_ready) ctl_d.st = ST_D0_RSP;
            end
            ST_D0_RSP: begin
                if (mem_rsp_valid) begin
                    ctx_we     = 1'b1;
                    ctx_w.cnt  = mem_rsp_data[CW-1:0];
                    ctx_w.last = mem_rsp_data[LAST_BIT];
                    ctx_w.dir  = mem_rsp_data[DIR_BIT];
                    ctl_d.st   = ST_D1_REQ;
                end
            end
            ST_D1_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = inc_out;
                if (mem_req_ready) ctl_d.st = ST_D1_RSP;
            end
            ST_D1_RSP: begin
                if (mem_rsp_valid) begin
                    ctx_we                = 1'b1;
                    ctx_w.addr            = mem_rsp_data;
                    ctl_d.need[ctl_q.cur] = 1'b0;
                    ctl_d.st              = (cur_ctx.cnt == '0) ? ST_STAT : ST_IDLE;
                end
            end
            ST_XF_REQ: begin
                inc_in        = cur_ctx.addr;
                mem_req_valid = 1'b1;
                mem_req_write = ~cur_ctx.dir;
                mem_req_addr  = cur_ctx.addr;
                mem_req_wdata = dev_wr_data[ctl_q.cur*DW +: DW];
                if (mem_req_ready) begin
                    if (!cur_ctx.dir) begin
                        dev_ack[ctl_q.cur] = 1'b1;
                        ctx_we     = 1'b1;
                        ctx_w.addr = inc_out;
                        ctx_w.cnt  = dec_out;
                        ctl_d.st   = dec_zero ? ST_STAT : ST_IDLE;
                    end else begin
                        ctl_d.st = ST_XF_RSP;
                    end
                end
            end
            ST_XF_RSP: begin
                inc_in = cur_ctx.addr;
                if (mem_rsp_valid) begin
                    dev_ack[ctl_q.cur] = 1'b1;
                    ctx_we     = 1'b1;
                    ctx_w.addr = inc_out;
                    ctx_w.cnt  = dec_out;
                    ctl_d.st   = dec_zero ? ST_STAT : ST_IDLE;
                end
            end
            ST_STAT: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = cur_pp;
                mem_req_wdata = status_word;
                if (mem_req_ready) ctl_d.st = ST_ADV1;
            end
            ST_ADV1: begin
                pp_we    = 1'b1;
                ctl_d.st = ST_ADV2;
            end
            ST_ADV2: begin
                pp_we = 1'b1;
                if (cur_ctx.last) begin
                    ctl_d.run[ctl_q.cur]  = 1'b0;
                    ctl_d.done[ctl_q.cur] = 1'b1;
                end else begin
                    ctl_d.need[ctl_q.cur] = 1'b1;
                end
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        if (reg_wr && sw_hit && sw_fld == 2'd1) begin
            if (reg_wdata[0]) begin
                ctl_d.run[sw_ch]  = 1'b1;
                ctl_d.need[sw_ch] = 1'b1;
                ctl_d.done[sw_ch] = 1'b0;
            end else begin
                ctl_d.run[sw_ch] = 1'b0;
            end
            if (reg_wdata[1]) ctl_d.done[sw_ch] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st   <= ST_IDLE;
            ctl_q.cur  <= '0;
            ctl_q.run  <= '0;
            ctl_q.need <= '0;
            ctl_q.done <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (sw_hit) begin
            case (sw_fld)
                2'd0: reg_rdata = pp_all[sw_ch];
                2'd1: reg_rdata = {{(DW-4){1'b0}}, ctx_all[sw_ch].last, ctx_all[sw_ch].dir,
                                   ctl_q.done[sw_ch], ctl_q.run[sw_ch]};
                2'd2: reg_rdata = ctx_all[sw_ch].addr;
                default: reg_rdata = {{(DW-CW){1'b0}}, ctx_all[sw_ch].cnt};
            endcase
        end
    end

    logic [1:0] rd_owed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_owed_q <= '0;
        end else if (mem_req_valid && mem_req_ready && !mem_req_write) begin
            rd_owed_q <= rd_owed_q + 2'd1;
        end else if (mem_rsp_valid && rd_owed_q != '0) begin
            rd_owed_q <= rd_owed_q - 2'd1;
        end
    end

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
                                            && $stable(mem_req_write));
    assert_one_owed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> rd_owed_q == '0);
    assert_ack_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_ack));
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_XF_REQ || ctl_q.st == ST_XF_RSP) |-> cur_ctx.cnt != '0);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        assert_done_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_done[c]) |-> !ctl_q.run[c]);
    end
endmodule

// File: tb/sim_dchain_dma.sv
`timescale 1ns/1ps
module sim_dchain_dma;
    localparam int NCH = 5;
    localparam int DW  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    dev_req = '0;
    logic [NCH*DW-1:0] dev_wr_data;
    logic [NCH-1:0]    dev_ack;
    logic [DW-1:0]     dev_rd_data;
    logic              mem_req_valid, mem_req_write;
    logic              mem_req_ready = 1'b0;
    logic [DW-1:0]     mem_req_addr, mem_req_wdata;
    logic              mem_rsp_valid = 1'b0;
    logic [DW-1:0]     mem_rsp_data = '0;
    logic              reg_wr = 1'b0;
    logic [4:0]        reg_addr = '0;
    logic [DW-1:0]     reg_wdata = '0;
    logic [DW-1:0]     reg_rdata;
    logic [NCH-1:0]    irq_done;

    always #4 clk = ~clk;

    dchain_dma #(.NCH(NCH)) u0 (.*);

    int checks = 0;
    int fails = 0;
    int hs_total = 0;
    int stall_viol = 0;
    bit finished = 0;

    logic [64:0]  memq[$];
    string        memtag[$];
    int           ackch[$];
    logic [31:0]  ackdat[$];
    bit           ackchk[$];
    logic [31:0]  mem [0:1023];

    for (genvar c = 0; c < NCH; c++) begin : g_wd
        assign dev_wr_data[c*DW +: DW] = 32'hD0D0_0000 + c;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic exp_rd(input logic [31:0] a, input string tag);
        memq.push_back({1'b0, a, 32'h0});
        memtag.push_back(tag);
    endtask

    task automatic exp_wr(input logic [31:0] a, input logic [31:0] d, input string tag);
        memq.push_back({1'b1, a, d});
        memtag.push_back(tag);
    endtask

    task automatic exp_ack(input int ch, input logic [31:0] d, input bit dochk);
        ackch.push_back(ch);
        ackdat.push_back(d);
        ackchk.push_back(dochk);
    endtask

    task automatic reg_write(input int ch, input int fld, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = {3'(ch), 2'(fld)}; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input int ch, input int fld, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = {3'(ch), 2'(fld)};
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic drain();
        wait (memq.size() == 0 && ackch.size() == 0);
        repeat (10) @(posedge clk);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // memory model and handshake capture
    bit          hs_q = 0, hs_w = 0;
    logic [31:0] hs_a, hs_d, pend_a;
    int          pend = 0;
    int          cyc = 0;
    bit          prev_stall = 0;
    logic [31:0] prev_addr;

    initial begin
        forever begin
            @(posedge clk); #1;
            cyc++;
            mem_rsp_valid = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem[pend_a[11:2]];
                end
            end
            if (hs_q) begin
                if (hs_w) mem[hs_a[11:2]] = hs_d;
                else begin pend = 2; pend_a = hs_a; end
                hs_q = 0;
            end
            mem_req_ready = (cyc % 3) != 1;
        end
    end

    // monitor: scoreboard pop and compare
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_stall && !(mem_req_valid && mem_req_addr == prev_addr)) stall_viol++;
                prev_stall = mem_req_valid && !mem_req_ready;
                prev_addr  = mem_req_addr;
                if (mem_req_valid && mem_req_ready) begin
                    hs_q = 1; hs_w = mem_req_write; hs_a = mem_req_addr; hs_d = mem_req_wdata;
                    hs_total++;
                    if (memq.size() == 0) begin
                        chk(0, "R10 unexpected request", {31'h0, mem_req_write, mem_req_addr}, 64'h0);
                    end else begin
                        logic [64:0] e;
                        string t;
                        e = memq.pop_front();
                        t = memtag.pop_front();
                        chk(e[64] == mem_req_write && e[63:32] == mem_req_addr &&
                            (!e[64] || e[31:0] == mem_req_wdata), t,
                            {mem_req_write ? mem_req_wdata : 32'h0, mem_req_addr},
                            {e[31:0], e[63:32]});
                    end
                end
                if (dev_ack != '0) begin
                    int ch;
                    ch = 0;
                    for (int i = 0; i < NCH; i++) if (dev_ack[i]) ch = i;
                    if (ackch.size() == 0) begin
                        chk(0, "R8 unexpected dev_ack", 64'(dev_ack), 64'h0);
                    end else begin
                        int ec;
                        logic [31:0] ed;
                        bit dc;
                        ec = ackch.pop_front(); ed = ackdat.pop_front(); dc = ackchk.pop_front();
                        chk(ec == ch && (!dc || ed == dev_rd_data), "R3/R8 dev_ack channel and data",
                            {32'(ch), dev_rd_data}, {32'(ec), ed});
                    end
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finish");
        report();
    end

    initial begin
        logic [31:0] r;
        int h0;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        // ch0 chain: memory-to-device then device-to-memory
        mem[32'h100 >> 2] = 32'h4000_0003; mem[32'h104 >> 2] = 32'h400;
        mem[32'h108 >> 2] = 32'h8000_0002; mem[32'h10C >> 2] = 32'h500;
        for (int k = 0; k < 3; k++) mem[(32'h400 >> 2) + k] = 32'h1111_0000 + k;
        // ch1..3 final memory-to-device, two words each
        for (int c = 1; c <= 3; c++) begin
            mem[(32'h1C0 + c*32'h40) >> 2]       = 32'hC000_0002;
            mem[((32'h1C0 + c*32'h40) >> 2) + 1] = 32'h500 + c*32'h100;
            for (int k = 0; k < 2; k++) mem[((32'h500 + c*32'h100) >> 2) + k] = 32'h2000_0000 + c*16 + k;
        end
        // ch4 zero-count final descriptor
        mem[32'h300 >> 2] = 32'h8000_0000; mem[32'h304 >> 2] = 32'h900;

        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk(irq_done == '0, "R1 irq_done after reset", 64'(irq_done), 64'h0);
        chk(!mem_req_valid, "R1 no request after reset", 64'(mem_req_valid), 64'h0);
        for (int f = 0; f < 4; f++) begin
            reg_read(2, f, r);
            chk(r == 32'h0, "R1 register zero after reset", 64'(r), 64'h0);
        end

        // ch0 two-descriptor chain: R2 R3 R4 R5 R6
        exp_rd(32'h100, "R2 descriptor word0"); exp_rd(32'h104, "R2 descriptor word1");
        for (int k = 0; k < 3; k++) begin
            exp_rd(32'h400 + 4*k, "R3 read sequence");
            exp_ack(0, 32'h1111_0000 + k, 1);
        end
        exp_wr(32'h100, 32'h6000_0000, "R5 status write non-final");
        exp_rd(32'h108, "R6 chained word0"); exp_rd(32'h10C, "R6 chained word1");
        for (int k = 0; k < 2; k++) begin
            exp_wr(32'h500 + 4*k, 32'hD0D0_0000, "R4 write sequence");
            exp_ack(0, 32'h0, 0);
        end
        exp_wr(32'h108, 32'hA000_0000, "R5 status write final");
        dev_req[0] = 1'b1;
        reg_write(0, 0, 32'h100);
        reg_write(0, 1, 32'h1);
        drain();
        chk(irq_done == 5'b00001, "R7 done after final descriptor", 64'(irq_done), 64'h1);
        reg_read(0, 0, r); chk(r == 32'h110, "R5 pointer advanced by 8", 64'(r), 64'h110);
        reg_read(0, 1, r); chk(r == 32'hA, "R12 status field", 64'(r), 64'hA);
        reg_read(0, 2, r); chk(r == 32'h508, "R12 buffer address field", 64'(r), 64'h508);
        reg_read(0, 3, r); chk(r == 32'h0, "R12 count field", 64'(r), 64'h0);

        // R8 round-robin over ch1..3
        for (int c = 1; c <= 3; c++) begin
            reg_write(c, 0, 32'h1C0 + c*32'h40);
            reg_write(c, 1, 32'h1);
        end
        for (int c = 1; c <= 3; c++) begin
            exp_rd(32'h1C0 + c*32'h40, "R8 fetch order"); exp_rd(32'h1C4 + c*32'h40, "R8 fetch order");
        end
        for (int c = 1; c <= 3; c++) begin
            exp_rd(32'h500 + c*32'h100, "R8 one word per grant");
            exp_ack(c, 32'h2000_0000 + c*16, 1);
        end
        for (int c = 1; c <= 3; c++) begin
            exp_rd(32'h504 + c*32'h100, "R8 second round");
            exp_ack(c, 32'h2000_0000 + c*16 + 1, 1);
            exp_wr(32'h1C0 + c*32'h40, 32'hE000_0000, "R5 status write round-robin");
        end
        dev_req[3:1] = 3'b111;
        drain();
        chk(irq_done == 5'b01111, "R7 done bits after round-robin", 64'(irq_done), 64'hF);

        // R10 running without request, then stopped with request
        h0 = hs_total;
        reg_write(4, 0, 32'h300);
        reg_write(4, 1, 32'h1);
        repeat (40) @(posedge clk);
        chk(hs_total == h0, "R10 no access without request", 64'(hs_total - h0), 64'h0);
        reg_read(4, 1, r); chk(r[0] == 1'b1, "R12 run bit reads set", 64'(r), 64'h1);
        reg_write(4, 1, 32'h0);
        dev_req[4] = 1'b1;
        repeat (40) @(posedge clk);
        chk(hs_total == h0, "R10 no access while stopped", 64'(hs_total - h0), 64'h0);

        // R11 zero-count descriptor
        exp_rd(32'h300, "R11 fetch word0"); exp_rd(32'h304, "R11 fetch word1");
        exp_wr(32'h300, 32'hA000_0000, "R11 status right after fetch");
        reg_write(4, 1, 32'h1);
        drain();
        chk(irq_done == 5'b11111, "R11 done with no data moved", 64'(irq_done), 64'h1F);
        reg_read(4, 0, r); chk(r == 32'h308, "R5 pointer advanced zero-count", 64'(r), 64'h308);

        // R7 clear by field 1 bit 1
        reg_write(0, 1, 32'h2);
        @(negedge clk);
        chk(irq_done == 5'b11110, "R7 done cleared by write", 64'(irq_done), 64'h1E);
        reg_read(0, 1, r); chk(r[0] == 1'b0, "R7 clear leaves channel stopped", 64'(r), 64'h0);

        chk(stall_viol == 0, "R9 request held while stalled", 64'(stall_viol), 64'h0);
        chk(memq.size() == 0, "R9 all expected requests seen", 64'(memq.size()), 64'h0);
        report();
    end
endmodule